// File: doc/BRIEF.md
# Switchable-length PRBS pattern generator

This block produces a pseudorandom stream of ones and zeros for driving a serial line, for example an RS-485 link, so that an eye diagram can be taken at the receiver. The stream is plain NRZ with no line coding. The core is a Fibonacci linear feedback shift register. A select input sets its active length to 16 or 17 bits, and that length picks the feedback polynomial. A bit-rate enable paces the register, so one clock can serve any line rate that divides it.

The register starts from a fixed nonzero seed. It leaves that seed only on enabled steps. The serial output is the top bit of the active length. A parallel byte output always shows the upper byte of the low sixteen bits, which can drive a byte-wide port. If the active length ever holds only zeros, the next enabled step reloads the seed, so the generator cannot stay stuck. A length change applies from the next enabled step and keeps the current register contents.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While reset is asserted, and until the first enabled step after reset, the register holds bit 17 = 0 and bits 16..1 = 0x55EB. The byte output then reads 0x55 and the serial output reads 0.
- R2: On a clock edge where `step_en` is low, the register keeps its value and both outputs stay unchanged.
- R3: On every enabled step, each bit of the active length moves up one position (Qn becomes Qn+1), and the new feedback bit enters Q1.
- R4: With `len17_sel` = 0 (16-bit length), the feedback bit is the XOR of the old Q16, Q15, Q13 and Q4.
- R5: With `len17_sel` = 1 (17-bit length), the feedback bit is the XOR of the old Q17 and Q14.
- R6: `top_byte` shows Q16..Q9, with Q16 in bit 7, in both lengths.
- R7: `nrz_out` is Q16 in 16-bit length and Q17 in 17-bit length.
- R8: Every enabled step in 16-bit length loads Q17 with 0, so that length runs as a pure 16-bit register.
- R9: If the active length is all zeros (Q16..Q1 in 16-bit length, Q17..Q1 in 17-bit length), the next enabled step loads the seed of R1 in place of a shift.
- R10: A change of `len17_sel` takes effect on the next enabled step and does not clear the register.
- R11: In 16-bit length, the sequence from the seed returns to the seed after exactly 65535 steps and never passes an all-zero state.
- R12: In 17-bit length, the sequence has a period of 131071 steps and never passes the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; loads the seed |
| step_en | input | 1 | Bit-rate enable; the register advances one step on each clock edge where it is high |
| len17_sel | input | 1 | Length select: 0 = 16-bit polynomial, 1 = 17-bit polynomial |
| nrz_out | output | 1 | Serial NRZ pattern bit, the top bit of the active length |
| top_byte | output | 8 | Q16..Q9 of the register |

## Verification
A wrong value in the upper byte of the register shows on `top_byte` in the same cycle. A wrong value in the lower byte climbs into `top_byte` within eight enabled steps. A wrong feedback bit enters Q1 at once and reaches the byte output eight steps later, and reaches the serial output after 16 or 17 steps. From then on the whole sequence departs from the expected one. Because each enabled step is compared against an independent arithmetic model over a full 16-bit period and a long run in 17-bit length, a tap error, a stray Q17 in 16-bit length or a missing reload shows up within a few steps of its first effect.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  // Register lengths supported by the generator
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned LONG_W  = 17;

  // Length select encoding
  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } prbs_len_e;

endpackage

// File: rtl/prbs_tap_xor.sv
// Parity of the register bits picked out by a tap mask.
module prbs_tap_xor #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   MASK = '0
) (
  input  logic [W-1:0] bits,
  output logic         fb
);

  logic [W-1:0] tapped;

  always_comb begin
    tapped = bits & MASK;
    fb     = ^tapped;
  end

endmodule

// File: rtl/prbs_zero_guard.sv
// Flags a register whose active length holds only zeros.
module prbs_zero_guard #(
  parameter int unsigned LONG_W  = 17,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [LONG_W-1:0] state,
  input  logic              len_long,
  output logic              zero_hit
);

  logic short_zero;
  logic upper_zero;

  always_comb begin
    short_zero = (state[SHORT_W-1:0] == '0);
    upper_zero = (state[LONG_W-1:SHORT_W] == '0);
    zero_hit   = len_long ? (short_zero && upper_zero) : short_zero;
  end

endmodule

// File: rtl/prbs_pattern_gen.sv
// Pseudorandom NRZ pattern source with a 16- or 17-bit feedback register.
module prbs_pattern_gen
  import prbs_pkg::*;
#(
  parameter logic [SHORT_W-1:0] SEED       = 16'h55EB,
  parameter logic [SHORT_W-1:0] SHORT_TAPS = 16'hD008,  // Q16 Q15 Q13 Q4
  parameter logic [LONG_W-1:0]  LONG_TAPS  = 17'h12000, // Q17 Q14
  parameter int unsigned        BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              len17_sel,
  output logic              nrz_out,
  output logic [BYTE_W-1:0] top_byte
);

  localparam int unsigned PAD_W   = LONG_W - SHORT_W;
  localparam int unsigned BYTE_LO = SHORT_W - BYTE_W;
  localparam logic [LONG_W-1:0] SEED_FULL = {{PAD_W{1'b0}}, SEED};

  prbs_len_e         len_mode;
  logic [LONG_W-1:0] state_q;
  logic [LONG_W-1:0] state_d;
  logic              fb_short;
  logic              fb_long;
  logic              zero_hit;

  assign len_mode = prbs_len_e'(len17_sel);

  // Feedback for the 16-bit length sees only the low sixteen bits
  prbs_tap_xor #(
    .W    (SHORT_W),
    .MASK (SHORT_TAPS)
  ) u_fb_short (
    .bits (state_q[SHORT_W-1:0]),
    .fb   (fb_short)
  );

  prbs_tap_xor #(
    .W    (LONG_W),
    .MASK (LONG_TAPS)
  ) u_fb_long (
    .bits (state_q),
    .fb   (fb_long)
  );

  prbs_zero_guard #(
    .LONG_W  (LONG_W),
    .SHORT_W (SHORT_W)
  ) u_guard (
    .state    (state_q),
    .len_long (len17_sel),
    .zero_hit (zero_hit)
  );

  // Next-state selection: reload, long shift or short shift
  always_comb begin
    if (zero_hit) begin
      state_d = SEED_FULL;
    end else if (len_mode == LEN_LONG) begin
      state_d = {state_q[LONG_W-2:0], fb_long};
    end else begin
      state_d = {{PAD_W{1'b0}}, state_q[SHORT_W-2:0], fb_short};
    end
  end

  // State register with explicit bit-rate enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_FULL;
    end else if (step_en) begin
      state_q <= state_d;
    end
  end

  // Outputs
  always_comb begin
    top_byte = state_q[SHORT_W-1:BYTE_LO];
    if (len_mode == LEN_LONG) begin
      nrz_out = state_q[LONG_W-1];
    end else begin
      nrz_out = state_q[SHORT_W-1];
    end
  end

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------

  // R2: no enable, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(state_q));

  // R3: long length shifts every bit up one place
  a_r3_shift_long: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && len17_sel && !zero_hit) |=>
      (state_q[LONG_W-1:1] == $past(state_q[LONG_W-2:0])));

  // R3: short length shifts the low sixteen bits up one place
  a_r3_shift_short: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !len17_sel && !zero_hit) |=>
      (state_q[SHORT_W-1:1] == $past(state_q[SHORT_W-2:0])));

  // R5: long-length feedback from Q17 and Q14
  a_r5_long_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && len17_sel && !zero_hit) |=>
      (state_q[0] == ($past(state_q[16]) ^ $past(state_q[13]))));

  // R8: short length keeps the extra bit cleared
  a_r8_short_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !len17_sel) |=> (state_q[LONG_W-1] == 1'b0));

  // R9: an all-zero active length is replaced by the seed
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && zero_hit) |=> (state_q == SEED_FULL));

  // R12: the full register never holds all zeros
  a_r12_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: tb/prbs_pattern_gen_tb.sv
module prbs_pattern_gen_tb;

  localparam logic [16:0] SEEDV   = 17'h055EB;
  localparam logic [16:0] ZHIGH   = 17'h10000;
  localparam int          WD_LIM  = 199000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic       len17_sel;
  logic       nrz_out;
  logic [7:0] top_byte;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [16:0] mstate;

  always #4 clk = ~clk;  // 125 MHz

  prbs_pattern_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .len17_sel (len17_sel),
    .nrz_out   (nrz_out),
    .top_byte  (top_byte)
  );

  // Reference step, written from the requirements
  function automatic logic [16:0] model_next(logic [16:0] s, logic lng);
    logic fb;
    if (lng) begin
      if (s == 17'd0) return SEEDV;
      fb = s[16] ^ s[13];
      return {s[15:0], fb};
    end else begin
      if (s[15:0] == 16'd0) return SEEDV;
      fb = s[15] ^ s[14] ^ s[12] ^ s[3];
      return {1'b0, s[14:0], fb};
    end
  endfunction

  function automatic int exp_out(logic [16:0] s, logic lng);
    logic b;
    b = lng ? s[16] : s[15];
    return {23'd0, b, s[15:8]};
  endfunction

  function automatic int dut_out();
    return {23'd0, nrz_out, top_byte};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One enabled step: drive at a falling edge, sample at the next one
  task automatic step1(string tag);
    step_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_en = 1'b0;
    mstate = model_next(mstate, len17_sel);
    chk(tag, dut_out(), exp_out(mstate, len17_sel));
  endtask

  initial begin
    repeat (WD_LIM) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", WD_LIM, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] s;
    int          n;
    int          zeros;
    int          prev;

    rst_n     = 1'b0;
    step_en   = 1'b0;
    len17_sel = 1'b0;

    // Arithmetic period counts (R11, R12)
    s = SEEDV; n = 0; zeros = 0;
    do begin
      s = model_next(s, 1'b0);
      n++;
      if (s[15:0] == 16'd0) zeros++;
    end while (s != SEEDV && n < 70000);
    chk("R11 period16", n, 65535);
    chk("R11 zero16", zeros, 0);
    s = SEEDV; n = 0; zeros = 0;
    do begin
      s = model_next(s, 1'b1);
      n++;
      if (s == 17'd0) zeros++;
    end while (s != SEEDV && n < 140000);
    chk("R12 period17", n, 131071);
    chk("R12 zero17", zeros, 0);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", dut_out(), 32'h055);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", dut_out(), 32'h055);
    mstate = SEEDV;

    // R2: no enable, nothing moves
    repeat (4) @(negedge clk);
    chk("R2 idle", dut_out(), 32'h055);

    // R4 R3: first 16-bit step from the seed gives 0xABD7
    step1("R4 first step");
    chk("R4 first value", dut_out(), 32'h1AB);

    // R11 R4 R6 R7 R8: rest of the 16-bit period
    for (int i = 1; i < 65535; i++) begin
      step1("R4 R6 R7 sweep16");
      if (mstate[15:0] == 16'd0) chk("R11 zero reached", 1, 0);
    end
    chk("R11 back at seed", int'(mstate), int'(SEEDV));
    chk("R11 dut at seed", dut_out(), 32'h055);

    // R5 R10: switch length without clearing; seed steps to 0x0ABD6
    len17_sel = 1'b1;
    @(negedge clk);
    chk("R10 no clear on change", dut_out(), 32'h055);
    step1("R5 first long step");
    chk("R5 first long value", dut_out(), 32'h0AB);

    // R5 R7 R12: run the 17-bit sequence until Q17 alone is set
    n = 0;
    while (mstate != ZHIGH && n < 131071) begin
      step1("R5 R7 sweep17");
      n++;
    end
    chk("R6 upper-only state", dut_out(), 32'h100);

    // R9: short length sees all zeros and reloads the seed
    len17_sel = 1'b0;
    @(negedge clk);
    chk("R7 short view of upper-only state", dut_out(), 32'h000);
    step1("R9 reload");
    chk("R9 reload value", dut_out(), 32'h055);

    // R8 R10: alternate lengths
    for (int i = 0; i < 24; i++) step1("R8 short run");
    len17_sel = 1'b1;
    for (int i = 0; i < 24; i++) step1("R10 long after short");
    len17_sel = 1'b0;
    for (int i = 0; i < 24; i++) step1("R10 short after long");

    // R2: hold in the middle of a run
    prev = dut_out();
    repeat (5) @(negedge clk);
    chk("R2 mid-run hold", dut_out(), prev);
    step1("R2 resume");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule